// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steers the power-on configuration flow of a programmable-logic device. When power is good it clears configuration memory for a fixed number of clocks and pulls an open-drain init line low during that time. It then waits until the line reads high, accepts configuration data until a load-complete strobe arrives, and finally runs an eight-phase start-up. The start-up raises done first, then lets the device outputs drive (global three-state released), and then lets storage elements change (global write enable released).

An active-low program request restarts the whole flow at any time. Three stall points exist: something outside can hold the init line low to delay loading; an option makes the two global releases wait until an external done-all input is high, so several devices start together; another option freezes start-up at a chosen phase until a clock-manager lock flag is set. The option inputs are static straps.

Top module: `cfg_startup_seq`

## Requirements
- R1: While pwr_ok is low (asynchronous reset) the outputs read init_drive_o=1, gsr_o=0, done_o=0, gts_hold_o=1, wr_block_o=1. Clearing starts on its own when pwr_ok rises.
- R2: init_drive_o (1 = pull the init line low) stays high for exactly CLR_CYCLES rising clock edges (default 16) after pwr_ok rises, and is low after the CLR_CYCLES-th edge.
- R3: After the drive is released, loading starts only on an edge where init_in reads 1. While init_in reads 0, load_done has no effect and gsr_o stays 0.
- R4: prog_n=0 at any edge returns the outputs to the R1 state. Clearing runs for CLR_CYCLES edges again once prog_n returns to 1.
- R5: load_done=1 at an edge while loading makes gsr_o high for exactly one cycle, starting at that edge. load_done in any other state is ignored.
- R6: Without stalls, done_o rises DONE_PH (default 4) edges after the edge that raised gsr_o. gsr_o is never high together with done_o.
- R7: Without stalls, gts_hold_o falls exactly one edge after done_o rises.
- R8: wr_block_o falls exactly one edge after gts_hold_o falls, and is never low while gts_hold_o is high.
- R9: With opt_sync_all=1, neither gts_hold_o nor wr_block_o is released while done_all_in=0, and done_o still rises.
- R10: With opt_lock_wait=1, start-up holds at phase opt_lock_phase (start-up phases are numbered 0 from the gsr edge and advance once per edge) while lock_in=0. It resumes on the first edge with lock_in=1.
- R11: After wr_block_o falls, all outputs hold their values until prog_n=0 or pwr_ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| pwr_ok | input | 1 | Power good; low is an asynchronous reset |
| prog_n | input | 1 | Active-low program request, restarts configuration |
| init_in | input | 1 | Level read back from the open-drain init line |
| load_done | input | 1 | Strobe: configuration data fully loaded |
| done_all_in | input | 1 | Wired done of all devices in the chain |
| lock_in | input | 1 | Clock-manager lock flag |
| opt_sync_all | input | 1 | Strap: global releases wait for done_all_in |
| opt_lock_wait | input | 1 | Strap: start-up waits for lock_in |
| opt_lock_phase | input | 3 | Strap: phase at which the lock wait applies |
| init_drive_o | output | 1 | 1 pulls the init line low |
| gsr_o | output | 1 | One-cycle global set/reset pulse |
| done_o | output | 1 | Configuration complete |
| gts_hold_o | output | 1 | 1 keeps device outputs three-stated |
| wr_block_o | output | 1 | 1 blocks writes to storage elements |

## Verification
The assertions check on every cycle the order of the releases (write enable never ahead of three-state, three-state never ahead of done), the single-cycle gsr pulse and its link to the load strobe, the reset effect of a program request, and the three stall conditions: init line low, missing done-all, and missing lock. Only the bench scenarios can show the absolute timing: the exact length of clearing, the four-edge gap from gsr to done, and the resume point after a stall ends. A cycle model in the bench compares all outputs under random traffic.

// File: rtl/cfg_startup_pkg.sv
`timescale 1ns/1ps
package cfg_startup_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR    = 2'd0,
    ST_INITWAIT = 2'd1,
    ST_LOAD     = 2'd2,
    ST_STARTUP  = 2'd3
  } cfg_state_e;

  // Phase frozen waiting for clock-manager lock
  function automatic logic lock_stall(input logic lock_en, input logic [31:0] ph,
                                      input logic [31:0] lock_ph, input logic locked);
    return lock_en && (ph == lock_ph) && !locked;
  endfunction

  // Phase frozen waiting for every device's done (only at the two release steps)
  function automatic logic sync_stall(input logic sync_en, input logic [31:0] ph,
                                      input logic [31:0] done_ph, input logic all_done);
    return sync_en && !all_done && ((ph == done_ph) || (ph == done_ph + 32'd1));
  endfunction

endpackage

// File: rtl/cfg_clear_timer.sv
`timescale 1ns/1ps
module cfg_clear_timer #(
  parameter int CLR_CYCLES = 16,
  localparam int CW = $clog2(CLR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic last
);
  logic [CW-1:0] cnt;

  assign last = active && (cnt == CW'(CLR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (active) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_phase_stepper.sv
`timescale 1ns/1ps
module cfg_phase_stepper
  import cfg_startup_pkg::*;
#(
  parameter int PHASES  = 8,
  parameter int DONE_PH = 4,
  localparam int PH_W   = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            start,
  input  logic            running,
  input  logic            sync_en,
  input  logic            all_done,
  input  logic            lock_en,
  input  logic [PH_W-1:0] lock_ph,
  input  logic            locked,
  output logic [PH_W-1:0] phase,
  output logic            adv,
  output logic            stall_lock,
  output logic            stall_sync
);
  logic at_last;

  assign at_last    = (phase == PH_W'(PHASES - 1));
  assign stall_lock = running && lock_stall(lock_en, 32'(phase), 32'(lock_ph), locked);
  assign stall_sync = running && sync_stall(sync_en, 32'(phase), 32'(DONE_PH), all_done);
  assign adv        = running && !at_last && !stall_lock && !stall_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (restart||start) phase <= '0;
    else if (adv)            phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/cfg_startup_seq.sv
`timescale 1ns/1ps
module cfg_startup_seq
  import cfg_startup_pkg::*;
#(
  parameter int CLR_CYCLES = 16,
  parameter int PHASES     = 8,
  parameter int DONE_PH    = 4,
  localparam int PH_W      = $clog2(PHASES),
  localparam int GTS_PH    = DONE_PH + 1,
  localparam int GWE_PH    = DONE_PH + 2
) (
  input  logic            clk,
  input  logic            pwr_ok,
  input  logic            prog_n,
  input  logic            init_in,
  input  logic            load_done,
  input  logic            done_all_in,
  input  logic            lock_in,
  input  logic            opt_sync_all,
  input  logic            opt_lock_wait,
  input  logic [PH_W-1:0] opt_lock_phase,
  output logic            init_drive_o,
  output logic            gsr_o,
  output logic            done_o,
  output logic            gts_hold_o,
  output logic            wr_block_o
);
  cfg_state_e      st;
  logic            restart;
  logic            ev_clear_end;
  logic            ev_load_accept;
  logic            ev_phase_adv;
  logic            stall_lock;
  logic            stall_sync;
  logic            gsr_q;
  logic [PH_W-1:0] phase;

  assign restart        = !prog_n;
  assign ev_load_accept = prog_n && (st == ST_LOAD) && load_done;

  cfg_clear_timer #(.CLR_CYCLES(CLR_CYCLES)) u_clear (
    .clk     (clk),
    .rst_n   (pwr_ok),
    .restart (restart),
    .active  (prog_n && (st == ST_CLEAR)),
    .last    (ev_clear_end)
  );

  cfg_phase_stepper #(.PHASES(PHASES), .DONE_PH(DONE_PH)) u_phase (
    .clk        (clk),
    .rst_n      (pwr_ok),
    .restart    (restart),
    .start      (ev_load_accept),
    .running    (prog_n && (st == ST_STARTUP)),
    .sync_en    (opt_sync_all),
    .all_done   (done_all_in),
    .lock_en    (opt_lock_wait),
    .lock_ph    (opt_lock_phase),
    .locked     (lock_in),
    .phase      (phase),
    .adv        (ev_phase_adv),
    .stall_lock (stall_lock),
    .stall_sync (stall_sync)
  );

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)       st <= ST_CLEAR;
    else if (restart)  st <= ST_CLEAR;
    else begin
      unique case (st)
        ST_CLEAR:    if (ev_clear_end) st <= ST_INITWAIT;
        ST_INITWAIT: if (init_in)      st <= ST_LOAD;
        ST_LOAD:     if (load_done)    st <= ST_STARTUP;
        default:                       st <= ST_STARTUP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) gsr_q <= 1'b0;
    else         gsr_q <= ev_load_accept;
  end

  always_comb begin
    init_drive_o = (st == ST_CLEAR);
    gsr_o        = gsr_q;
    done_o       = (st == ST_STARTUP) && (phase >= PH_W'(DONE_PH));
    gts_hold_o   = !((st == ST_STARTUP) && (phase >= PH_W'(GTS_PH)));
    wr_block_o   = !((st == ST_STARTUP) && (phase >= PH_W'(GWE_PH)));
  end
endmodule

// File: rtl/cfg_startup_chk.sv
`timescale 1ns/1ps
module cfg_startup_chk
  import cfg_startup_pkg::*;
#(
  parameter int PH_W = 3
) (
  input logic            clk,
  input logic            pwr_ok,
  input logic            prog_n,
  input logic            init_in,
  input logic            load_done,
  input logic            done_all_in,
  input logic            lock_in,
  input logic            opt_sync_all,
  input logic            opt_lock_wait,
  input logic [PH_W-1:0] opt_lock_phase,
  input logic            init_drive_o,
  input logic            gsr_o,
  input logic            done_o,
  input logic            gts_hold_o,
  input logic            wr_block_o,
  input cfg_state_e      st,
  input logic [PH_W-1:0] phase
);
  assert_init_hold_blocks_load_R3: assert property (@(posedge clk) disable iff (!pwr_ok)
    (prog_n && st == ST_INITWAIT && !init_in) |=> (st == ST_INITWAIT && !gsr_o));

  assert_prog_resets_outputs_R4: assert property (@(posedge clk) disable iff (!pwr_ok)
    !prog_n |=> (init_drive_o && gts_hold_o && wr_block_o && !done_o && !gsr_o));

  assert_gsr_from_strobe_R5: assert property (@(posedge clk) disable iff (!pwr_ok)
    gsr_o |-> $past(load_done));

  assert_gsr_single_R5: assert property (@(posedge clk) disable iff (!pwr_ok)
    gsr_o |=> !gsr_o);

  assert_gsr_before_done_R6: assert property (@(posedge clk) disable iff (!pwr_ok)
    gsr_o |-> !done_o);

  assert_gts_after_done_R7: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(gts_hold_o) |-> (done_o && $past(done_o)));

  assert_gwe_after_gts_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(wr_block_o) |-> $past(!gts_hold_o));

  assert_release_order_R8: assert property (@(posedge clk) disable iff (!pwr_ok)
    !wr_block_o |-> (!gts_hold_o && done_o));

  assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!pwr_ok)
    (prog_n && opt_sync_all && !done_all_in && gts_hold_o) |=> gts_hold_o);

  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!pwr_ok)
    (prog_n && opt_lock_wait && !lock_in && st == ST_STARTUP && phase == opt_lock_phase)
      |=> (phase == $past(phase)));

  assert_user_mode_stays_R11: assert property (@(posedge clk) disable iff (!pwr_ok)
    (prog_n && !wr_block_o) |=> !wr_block_o);
endmodule

bind cfg_startup_seq cfg_startup_chk #(.PH_W(PH_W)) u_chk (
  .clk            (clk),
  .pwr_ok         (pwr_ok),
  .prog_n         (prog_n),
  .init_in        (init_in),
  .load_done      (load_done),
  .done_all_in    (done_all_in),
  .lock_in        (lock_in),
  .opt_sync_all   (opt_sync_all),
  .opt_lock_wait  (opt_lock_wait),
  .opt_lock_phase (opt_lock_phase),
  .init_drive_o   (init_drive_o),
  .gsr_o          (gsr_o),
  .done_o         (done_o),
  .gts_hold_o     (gts_hold_o),
  .wr_block_o     (wr_block_o),
  .st             (st),
  .phase          (phase)
);

// File: tb/sim_cfg_startup_seq.sv
`timescale 1ns/1ps
module sim_cfg_startup_seq;
  localparam int CLR = 16;
  localparam int DPH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic pwr_ok = 0, prog_n = 1, ext_hold = 0, load_done = 0;
  logic done_all = 0, lock = 0, o_sync = 0, o_lock = 0;
  logic [2:0] o_lph = 3'd0;
  wire init_drive, gsr, done, gts_hold, wr_block;
  wire init_line = !init_drive && !ext_hold;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model: stage 0 clear, 1 wait line, 2 load, 3 start-up
  int m_stage = 0, m_cnt = 0, m_ph = 0;
  bit m_gsr = 0;

  cfg_startup_seq u0 (
    .clk(clk), .pwr_ok(pwr_ok), .prog_n(prog_n), .init_in(init_line),
    .load_done(load_done), .done_all_in(done_all), .lock_in(lock),
    .opt_sync_all(o_sync), .opt_lock_wait(o_lock), .opt_lock_phase(o_lph),
    .init_drive_o(init_drive), .gsr_o(gsr), .done_o(done),
    .gts_hold_o(gts_hold), .wr_block_o(wr_block));

  function automatic bit may_go(int ph);
    if (ph >= 7) return 0;
    if (o_lock && ph == int'(o_lph) && !lock) return 0;
    if (o_sync && !done_all && (ph == DPH || ph == DPH + 1)) return 0;
    return 1;
  endfunction

  function automatic bit exp_out(int sel);
    case (sel)
      0: return m_stage == 0;
      1: return m_gsr;
      2: return m_stage == 3 && m_ph >= DPH;
      3: return !(m_stage == 3 && m_ph >= DPH + 1);
      default: return !(m_stage == 3 && m_ph >= DPH + 2);
    endcase
  endfunction

  function automatic logic act_out(int sel);
    case (sel)
      0: return init_drive;
      1: return gsr;
      2: return done;
      3: return gts_hold;
      default: return wr_block;
    endcase
  endfunction

  task automatic step_model();
    bit line;
    line = (m_stage != 0) && !ext_hold;
    m_gsr = 0;
    if (!pwr_ok || !prog_n) begin
      m_stage = 0; m_cnt = 0; m_ph = 0;
    end else begin
      case (m_stage)
        0: begin
          if (m_cnt == CLR - 1) begin m_stage = 1; m_cnt = 0; end
          else m_cnt++;
        end
        1: if (line) m_stage = 2;
        2: if (load_done) begin m_stage = 3; m_ph = 0; m_gsr = 1; end
        default: if (may_go(m_ph)) m_ph++;
      endcase
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    string tags[5] = '{"R2", "R5", "R6", "R7", "R8"};
    string names[5] = '{"init_drive", "gsr", "done", "gts_hold", "wr_block"};
    @(negedge clk);
    step_model();
    for (int i = 0; i < 5; i++)
      check(tags[i], {"model ", names[i]}, int'(act_out(i)), int'(exp_out(i)));
  endtask

  task automatic wait_edges(input int sel, input logic val, output int n);
    n = 0;
    while (act_out(sel) !== val) begin
      tick(); n++;
      if (n > 1000) begin n = -1; return; end
    end
  endtask

  task automatic restart_and_load();
    int n;
    prog_n = 0; tick(); prog_n = 1;
    wait_edges(0, 1'b0, n);
    tick();
    load_done = 1; tick(); load_done = 0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0c3f));
    // R1 reset state
    repeat (3) tick();
    check("R1", "reset init_drive", int'(init_drive), 1);
    check("R1", "reset gsr", int'(gsr), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset gts_hold", int'(gts_hold), 1);
    check("R1", "reset wr_block", int'(wr_block), 1);

    // R2 clear length after power good
    pwr_ok = 1;
    wait_edges(0, 1'b0, n);
    check("R2", "clear edges", n, CLR);
    // R5 strobe in line-wait state ignored
    load_done = 1; tick(); load_done = 0;
    check("R5", "gsr on early strobe", int'(gsr), 0);
    load_done = 1; tick(); load_done = 0;
    check("R5", "gsr after strobe", int'(gsr), 1);
    wait_edges(2, 1'b1, n);
    check("R6", "gsr to done edges", n, DPH);
    wait_edges(3, 1'b0, n);
    check("R7", "done to gts edges", n, 1);
    wait_edges(4, 1'b0, n);
    check("R8", "gts to gwe edges", n, 1);
    load_done = 1; repeat (20) tick(); load_done = 0;
    check("R11", "user mode done", int'(done), 1);
    check("R11", "user mode wr_block", int'(wr_block), 0);
    check("R5", "strobe in user mode", int'(gsr), 0);

    // R4 program request
    prog_n = 0; tick();
    check("R4", "prog init_drive", int'(init_drive), 1);
    check("R4", "prog outputs", {int'(done), int'(gts_hold), int'(wr_block)}, {0, 1, 1});
    repeat (5) tick();
    prog_n = 1;
    wait_edges(0, 1'b0, n);
    check("R4", "clear edges after prog", n, CLR);

    // R3 external init hold
    prog_n = 0; tick(); prog_n = 1; ext_hold = 1;
    wait_edges(0, 1'b0, n);
    for (int i = 0; i < 10; i++) begin
      load_done = 1; tick();
      check("R3", "gsr while line held", int'(gsr), 0);
    end
    load_done = 0; ext_hold = 0; tick();
    load_done = 1; tick(); load_done = 0;
    check("R3", "gsr after line free", int'(gsr), 1);

    // R9 multi-device sync
    o_sync = 1; done_all = 0;
    restart_and_load();
    repeat (12) tick();
    check("R9", "done without all", int'(done), 1);
    check("R9", "gts held without all", int'(gts_hold), 1);
    done_all = 1;
    wait_edges(3, 1'b0, n);
    check("R9", "gts after all", n, 1);
    wait_edges(4, 1'b0, n);
    check("R9", "gwe after all", n, 1);
    o_sync = 0;

    // R10 lock wait at phase 2
    o_lock = 1; o_lph = 3'd2; lock = 0;
    restart_and_load();
    repeat (12) tick();
    check("R10", "done without lock", int'(done), 0);
    lock = 1;
    wait_edges(2, 1'b1, n);
    check("R10", "lock to done edges", n, DPH - 2);
    o_lock = 0;

    // random traffic against the bench model
    for (int r = 0; r < 300; r++) begin
      o_sync = 1'($urandom_range(0, 1));
      o_lock = 1'($urandom_range(0, 1));
      o_lph  = 3'($urandom_range(0, 7));
      for (int c = 0; c < 60; c++) begin
        load_done = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 7) == 0) lock = ~lock;
        if ($urandom_range(0, 7) == 0) done_all = ~done_all;
        if ($urandom_range(0, 9) == 0) ext_hold = ~ext_hold;
        prog_n = ($urandom_range(0, 49) != 0);
        if (!pwr_ok) pwr_ok = 1;
        else if ($urandom_range(0, 199) == 0) pwr_ok = 0;
        tick();
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule